// File: doc/BRIEF.md
# Latched serial-to-parallel shift register

The block turns a serial bit stream into a parallel word. Bits enter on a serial input and move one place up on every rising edge of a shift clock. A separate latch clock copies the whole shift register into a holding register, and the holding register drives the parallel outputs. Because of this, the parallel word only changes when the latch clock rises, and a new word can be shifted in while the old one is still on the outputs.

The block can chain several 8-stage devices, set by the parameter `DEV_COUNT`. A carry bit leaves the top stage of each device and enters the bottom stage of the next device. The carry of the last device is brought out so that further devices can be added outside the block.

An active-low asynchronous clear empties the shift stages only. An active-low output enable puts the parallel outputs into high impedance. The same result is also given as a plain data bus and an enable flag, so that a checker can read it without resolving Z.

Top module: `sipo_latch_chain`

## Requirements
- R1: On each rising edge of `sclk` with `clr_n` high, `ser_in` enters stage 0 and every stage takes the value of the stage below it. Stage i of device d is bit 8*d+i of the chain word.
- R2: `ser_out` always shows the top stage of the last device. After a shift it holds what the stage just below held before that edge.
- R3: On each rising edge of `lclk`, every shift stage is copied into the holding register. `par_data` shows the holding register at all times.
- R4: While `clr_n` is low, all shift stages are zero at once, with no clock edge needed. The holding register and `par_data` keep their value.
- R5: A rising edge of `lclk` while the stages are cleared loads all zeros into the holding register.
- R6: When `sclk` and `lclk` rise on the same edge, the holding register captures the stage contents from before that shift, so it lags the shift register by one edge.
- R7: While `oe_n` is low, `par_q` equals the holding register and `par_en` is 1. While `oe_n` is high, `par_q` is high impedance on every bit and `par_en` is 0.
- R8: Changing `oe_n` never alters the shift stages or the holding register. Shifting and latching work the same while the outputs are disabled.
- R9: A shift edge while `clr_n` is low leaves the stages at zero. After `clr_n` goes high, the next shift edge acts normally.
- R10: The top stage of device d feeds stage 0 of device d+1. The first bit shifted in reaches bit 8*DEV_COUNT-1 and `ser_out` after exactly 8*DEV_COUNT shift edges, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Shift clock, rising edge active |
| lclk | input | 1 | Latch clock for the holding register, rising edge active |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| ser_in | input | 1 | Serial data into stage 0 of device 0 |
| par_q | output | 8*DEV_COUNT | Parallel outputs with three states |
| par_data | output | 8*DEV_COUNT | Holding register value, always driven |
| par_en | output | 1 | 1 while `par_q` is driven |
| ser_out | output | 1 | Carry out of the top stage of the last device |

## Verification
The main path is tested with a table of 16-bit words that are shifted in MSB first and then latched:
- All zeros and all ones show stuck stages.
- Alternating and asymmetric words show swapped or misordered stages.
- Words with single bits at the ends show an off-by-one in the shift length or in the carry between the two devices.

Directed sequences then check the shift clock and latch clock on their own and tied together, which separates capture of the old word from capture of the new word. They also check clearing while a word is latched and shift edges during a clear, and toggle the output enable around shifting and latching.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    // Number of stages in one chained device.
    localparam int unsigned DEV_STAGES = 8;

    typedef logic [DEV_STAGES-1:0] dev_word_t;

    // State of the shift stages of one device.
    typedef struct packed {
        dev_word_t stg;
    } shift_st_t;

    // State of the holding register of one device.
    typedef struct packed {
        dev_word_t val;
    } hold_st_t;

endpackage

// File: rtl/sipo_dev_shift.sv
module sipo_dev_shift
    import sipo_pkg::*;
(
    input  logic      sclk_i,
    input  logic      clr_ni,
    input  logic      ser_i,
    output dev_word_t stg_o
);

    shift_st_t st_d;
    shift_st_t st_q;

    // Next value: every stage moves up by one, and the serial bit enters stage 0.
    always_comb begin
        st_d     = st_q;
        st_d.stg = {st_q.stg[DEV_STAGES-2:0], ser_i};
    end

    // A low clear empties the stages at once and holds them empty.
    always_ff @(posedge sclk_i or negedge clr_ni) begin
        if (!clr_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stg_o = st_q.stg;

endmodule

// File: rtl/sipo_dev_hold.sv
module sipo_dev_hold
    import sipo_pkg::*;
(
    input  logic      lclk_i,
    input  dev_word_t stg_i,
    output dev_word_t val_o
);

    hold_st_t hold_d;
    hold_st_t hold_q;

    always_comb begin
        hold_d     = hold_q;
        hold_d.val = stg_i;
    end

    // No reset here: the clear of the shift stages must leave this register alone.
    always_ff @(posedge lclk_i) begin
        hold_q <= hold_d;
    end

    assign val_o = hold_q.val;

endmodule

// File: rtl/sipo_out_drv.sv
module sipo_out_drv #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             oe_ni,
    input  logic [WIDTH-1:0] val_i,
    output logic [WIDTH-1:0] par_q_o,
    output logic [WIDTH-1:0] par_data_o,
    output logic             par_en_o
);

    assign par_en_o   = ~oe_ni;
    assign par_data_o = val_i;
    assign par_q_o    = oe_ni ? {WIDTH{1'bz}} : val_i;

endmodule

// File: rtl/sipo_latch_chain.sv
module sipo_latch_chain
    import sipo_pkg::*;
#(
    parameter  int unsigned DEV_COUNT  = 1,
    localparam int unsigned TOTAL_BITS = DEV_COUNT * DEV_STAGES
) (
    input  logic                  sclk,
    input  logic                  lclk,
    input  logic                  clr_n,
    input  logic                  oe_n,
    input  logic                  ser_in,
    output logic [TOTAL_BITS-1:0] par_q,
    output logic [TOTAL_BITS-1:0] par_data,
    output logic                  par_en,
    output logic                  ser_out
);

    // chain[d] is the serial input of device d.
    logic [DEV_COUNT:0]    chain;
    logic [TOTAL_BITS-1:0] shift_vec;
    logic [TOTAL_BITS-1:0] hold_vec;

    assign chain[0] = ser_in;

    for (genvar d = 0; d < DEV_COUNT; d++) begin : g_dev
        sipo_dev_shift u_shift (
            .sclk_i (sclk),
            .clr_ni (clr_n),
            .ser_i  (chain[d]),
            .stg_o  (shift_vec[d*DEV_STAGES +: DEV_STAGES])
        );

        sipo_dev_hold u_hold (
            .lclk_i (lclk),
            .stg_i  (shift_vec[d*DEV_STAGES +: DEV_STAGES]),
            .val_o  (hold_vec[d*DEV_STAGES +: DEV_STAGES])
        );

        // The top stage of this device feeds the next device.
        assign chain[d+1] = shift_vec[d*DEV_STAGES + DEV_STAGES - 1];
    end

    assign ser_out = chain[DEV_COUNT];

    sipo_out_drv #(
        .WIDTH (TOTAL_BITS)
    ) u_drv (
        .oe_ni      (oe_n),
        .val_i      (hold_vec),
        .par_q_o    (par_q),
        .par_data_o (par_data),
        .par_en_o   (par_en)
    );

endmodule

// File: rtl/sipo_latch_chk.sv
module sipo_latch_chk #(
    parameter int unsigned TOTAL_BITS = 8
) (
    input logic                  sclk,
    input logic                  lclk,
    input logic                  clr_n,
    input logic                  ser_in,
    input logic                  ser_out,
    input logic [TOTAL_BITS-1:0] shift_vec,
    input logic [TOTAL_BITS-1:0] hold_vec
);

    // 1 when the last sclk edge happened with clr_n high and no clear has come since.
    logic clean_q;
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) clean_q <= 1'b0;
        else        clean_q <= 1'b1;
    end

    // 1 when the last lclk edge happened with clr_n high and no clear has come since.
    logic primed_q;
    always_ff @(posedge lclk or negedge clr_n) begin
        if (!clr_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // Records whether the stages were cleared at the last lclk edge.
    logic clr_at_latch_q;
    always_ff @(posedge lclk) begin
        clr_at_latch_q <= ~clr_n;
    end

    // R1: stages move up by one, and ser_in enters stage 0.
    p_shift_up_r1: assert property (@(posedge sclk) disable iff (!clr_n)
        clean_q |-> shift_vec == {$past(shift_vec[TOTAL_BITS-2:0]), $past(ser_in)});

    // R2: the carry out shows the old next-to-top stage.
    p_carry_r2: assert property (@(posedge sclk) disable iff (!clr_n)
        clean_q |-> ser_out == $past(shift_vec[TOTAL_BITS-2]));

    // R3 and R6: the holding register takes the stage contents present at the latch edge.
    p_latch_copy_r3: assert property (@(posedge lclk) disable iff (!clr_n)
        primed_q |-> hold_vec == $past(shift_vec));

    // R5: a latch edge during a clear loads zeros.
    p_latch_zero_r5: assert property (@(posedge lclk) disable iff (!clr_n)
        clr_at_latch_q |-> hold_vec == '0);

endmodule

bind sipo_latch_chain sipo_latch_chk #(
    .TOTAL_BITS (TOTAL_BITS)
) u_chk (
    .sclk      (sclk),
    .lclk      (lclk),
    .clr_n     (clr_n),
    .ser_in    (ser_in),
    .ser_out   (ser_out),
    .shift_vec (shift_vec),
    .hold_vec  (hold_vec)
);

// File: tb/sipo_latch_chain_tb.sv
module sipo_latch_chain_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DEVS       = 2;
    localparam int unsigned W          = DEVS * 8;
    localparam int unsigned NVEC       = 6;

    typedef struct packed {
        logic [15:0] pattern;
        logic [15:0] exp_par;
        logic        exp_ser;
    } vec_t;

    // Each word is shifted in MSB first. After 16 shifts and a latch, the word should appear unchanged.
    localparam vec_t VECS [NVEC] = '{
        '{16'h0000, 16'h0000, 1'b0},
        '{16'hFFFF, 16'hFFFF, 1'b1},
        '{16'hA55A, 16'hA55A, 1'b1},
        '{16'h8001, 16'h8001, 1'b1},
        '{16'h1234, 16'h1234, 1'b0},
        '{16'h00FF, 16'h00FF, 1'b0}
    };

    logic         sclk   = 1'b0;
    logic         lclk   = 1'b0;
    logic         clr_n  = 1'b0;
    logic         oe_n   = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_q;
    logic [W-1:0] par_data;
    logic         par_en;
    logic         ser_out;

    int n_checks = 0;
    int n_fail   = 0;

    sipo_latch_chain #(
        .DEV_COUNT (DEVS)
    ) u_dut (
        .sclk     (sclk),
        .lclk     (lclk),
        .clr_n    (clr_n),
        .oe_n     (oe_n),
        .ser_in   (ser_in),
        .par_q    (par_q),
        .par_data (par_data),
        .par_en   (par_en),
        .ser_out  (ser_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        ser_in = b;
        #(CLK_PERIOD/2) sclk = 1'b1;
        #(CLK_PERIOD/2) sclk = 1'b0;
    endtask

    task automatic latch();
        #(CLK_PERIOD/2) lclk = 1'b1;
        #(CLK_PERIOD/2) lclk = 1'b0;
    endtask

    task automatic tied(input logic b);
        ser_in = b;
        #(CLK_PERIOD/2);
        sclk = 1'b1;
        lclk = 1'b1;
        #(CLK_PERIOD/2);
        sclk = 1'b0;
        lclk = 1'b0;
    endtask

    task automatic load_word(input logic [15:0] w);
        for (int b = 15; b >= 0; b--) shift_bit(w[b]);
    endtask

    task automatic pulse_clear();
        clr_n = 1'b0;
        #1;
        clr_n = 1'b1;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Reset state.
        #(CLK_PERIOD);
        check("R4 reset ser_out", 32'(ser_out), 32'd0);
        latch();
        check("R5 latch during clear", 32'(par_data), 32'h0);
        check("R7 enable low gives par_en", 32'(par_en), 32'd1);
        clr_n = 1'b1;
        #(CLK_PERIOD);

        // Table of words.
        for (int i = 0; i < NVEC; i++) begin
            load_word(VECS[i].pattern);
            latch();
            check("R3 R10 table par_data", 32'(par_data), 32'(VECS[i].exp_par));
            check("R2 table ser_out", 32'(ser_out), 32'(VECS[i].exp_ser));
        end

        // R1: one bit enters stage 0, then moves up.
        pulse_clear();
        shift_bit(1'b1);
        latch();
        check("R1 first bit at stage 0", 32'(par_data), 32'h0001);
        shift_bit(1'b0);
        latch();
        check("R1 bit moved up", 32'(par_data), 32'h0002);

        // R4: the clear acts at once and spares the holding register.
        load_word(16'hA55A);
        latch();
        check("R3 word latched", 32'(par_data), 32'hA55A);
        clr_n = 1'b0;
        #1;
        check("R4 immediate clear ser_out", 32'(ser_out), 32'd0);
        #(CLK_PERIOD);
        check("R4 hold kept", 32'(par_data), 32'hA55A);
        latch();
        check("R5 zeros latched", 32'(par_data), 32'h0000);

        // R9: shifts during the clear are lost, and the release acts before the next edge.
        shift_bit(1'b1);
        shift_bit(1'b1);
        shift_bit(1'b1);
        clr_n = 1'b1;
        #1;
        latch();
        check("R9 shifts under clear lost", 32'(par_data), 32'h0000);
        shift_bit(1'b1);
        latch();
        check("R9 shift after release", 32'(par_data), 32'h0001);

        // R6: tied clocks make the holding register lag by one edge.
        pulse_clear();
        latch();
        tied(1'b1);
        check("R6 tied first", 32'(par_data), 32'h0000);
        tied(1'b1);
        check("R6 tied second", 32'(par_data), 32'h0001);
        tied(1'b0);
        check("R6 tied third", 32'(par_data), 32'h0003);

        // R7 and R8: output enable.
        load_word(16'h3C3C);
        latch();
        oe_n = 1'b1;
        #1;
        check("R7 disabled par_en", 32'(par_en), 32'd0);
        check("R8 hold kept on disable", 32'(par_data), 32'h3C3C);
        load_word(16'hC3C3);
        latch();
        check("R8 latch while disabled", 32'(par_data), 32'hC3C3);
        oe_n = 1'b0;
        #1;
        oe_n = 1'b1;
        #1;
        oe_n = 1'b0;
        #1;
        check("R7 enabled par_q", 32'(par_q), 32'hC3C3);
        check("R8 ser_out kept on toggles", 32'(ser_out), 32'd1);
        latch();
        check("R8 stages kept on toggles", 32'(par_data), 32'hC3C3);

        // R10 and R2: carry between devices and arrival at the end of the chain.
        pulse_clear();
        shift_bit(1'b1);
        for (int k = 0; k < 7; k++) shift_bit(1'b0);
        latch();
        check("R10 top of device 0", 32'(par_data), 32'h0080);
        shift_bit(1'b0);
        latch();
        check("R10 carried into device 1", 32'(par_data), 32'h0100);
        for (int k = 0; k < 6; k++) shift_bit(1'b0);
        check("R10 not yet at end", 32'(ser_out), 32'd0);
        shift_bit(1'b0);
        check("R2 R10 arrived after 16 shifts", 32'(ser_out), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule